// File: doc/BRIEF.md
# Log-to-Float Converter

This block turns a flagged base-2 logarithmic number into a normalised binary floating-point number. The input word has a two-bit class code, a sign, a signed two's-complement integer part of `INT_W` bits and an unsigned fraction of `FRAC_W` bits. The output has a sign, a biased exponent of `INT_W` bits and a stored mantissa fraction of `MAN_W` bits with a hidden leading one.

The integer part plus the bias `2^(INT_W-1)-1` becomes the exponent. The mantissa is `2^f`, where `f` is the log fraction in [0,1), so the mantissa lies in [1,2). It is not read from one table that covers the whole fraction. The fraction is cut into `SLICES` equal slices. Each slice addresses a small table that holds 2 raised to the slice value at that slice's bit weight. The table outputs are multiplied together in a chain, with guard bits, and rounded to nearest once at the end.

The block is fully pipelined. It accepts one word per clock and uses a valid bit that travels with the data. Denormal results are flushed to zero.

Top module: `lns_to_fp_conv`

## Requirements
- R1: Class code 00 (zero) gives exponent 0 and mantissa 0.
- R2: Class code 10 (infinity) gives an all-ones exponent and mantissa 0.
- R3: Class code 11 (NaN) gives an all-ones exponent and a mantissa whose top bit alone is set.
- R4: For class code 01 (normal), when no rounding carry occurs, the exponent equals the signed integer part plus `2^(INT_W-1)-1`.
- R5: For a normal input whose biased exponent would be zero or negative, the output is exponent 0 and mantissa 0. This case includes the most negative integer part.
- R6: For a normal input, `1 + mantissa/2^MAN_W` lies within one mantissa ulp of `2^(fraction/2^FRAC_W)`.
- R7: When rounding the mantissa reaches 2.0, the mantissa becomes 0 and the exponent rises by one.
- R8: When that rise would produce the all-ones exponent, the output is infinity (all-ones exponent, mantissa 0).
- R9: The output sign always equals the input sign, for every class code.
- R10: `out_valid` is low after reset and repeats `in_valid` exactly `SLICES` cycles later, including gaps in the input stream.
- R11: A normal input with a zero fraction gives mantissa 0 exactly, with the exponent from R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the valid pipeline |
| in_valid | input | 1 | Input word present |
| in_flags | input | 2 | Class code: 00 zero, 01 normal, 10 infinity, 11 NaN |
| in_sign | input | 1 | Sign of the value |
| in_int | input | INT_W | Two's-complement integer part of the log |
| in_frac | input | FRAC_W | Fraction part of the log |
| out_valid | output | 1 | Output word present |
| out_sign | output | 1 | Sign of the result |
| out_exp | output | INT_W | Biased exponent |
| out_man | output | MAN_W | Mantissa fraction without the hidden one |

## Verification
Two instances are swept over every combination of class code, integer part and fraction. The first has an 8-bit mantissa and two slices. The second has a 5-bit mantissa and four slices. Valid gaps are placed in the stream, so a wrong latency or a stuck valid bit shows up as a misaligned result.

Zero fractions pin down the exact 1.0 case. Nonzero fractions are compared against a real-valued `2^f` with a one-ulp tolerance, which separates a bad table weight or product truncation from legal rounding. The narrow-mantissa instance rounds fractions close to 1 up to 2.0. With the largest integer part, it shows the mantissa wrap and the overflow to infinity. The most negative integer parts show the zero flush.

// File: rtl/lns_to_fp_conv.sv
module lns_to_fp_conv #(
  parameter int INT_W  = 4,
  parameter int FRAC_W = 8,
  parameter int MAN_W  = 8,
  parameter int SLICES = 2,
  parameter int GUARD  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_flags,
  input  logic              in_sign,
  input  logic [INT_W-1:0]  in_int,
  input  logic [FRAC_W-1:0] in_frac,
  output logic              out_valid,
  output logic              out_sign,
  output logic [INT_W-1:0]  out_exp,
  output logic [MAN_W-1:0]  out_man
);
  localparam int SLICE_W = FRAC_W / SLICES;
  localparam int ENTRIES = 1 << SLICE_W;
  localparam int P       = MAN_W + GUARD;
  localparam int PW      = P + 1;
  localparam int BIAS    = (1 << (INT_W - 1)) - 1;
  localparam int LAST    = SLICES - 1;
  localparam real SCALE  = 2.0 ** P;
  localparam logic [INT_W-1:0] EMAX    = {INT_W{1'b1}};
  localparam logic [MAN_W-1:0] NAN_MAN = MAN_W'(1) << (MAN_W - 1);
  localparam logic [PW-1:0]    ONE     = PW'(1) << P;

  localparam logic [1:0] K_ZERO = 2'b00;
  localparam logic [1:0] K_NORM = 2'b01;
  localparam logic [1:0] K_INF  = 2'b10;

  logic [PW-1:0] tab [SLICES][ENTRIES];

  for (genvar j = 0; j < SLICES; j++) begin : g_tab
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      localparam real EXPO = real'(e) / (2.0 ** (SLICE_W * (j + 1)));
      assign tab[j][e] = PW'($rtoi((2.0 ** EXPO) * SCALE + 0.5));
    end
  end

  logic              vld_q  [SLICES];
  logic              sgn_q  [SLICES];
  logic [1:0]        kind_q [SLICES];
  logic [INT_W-1:0]  exp_q  [SLICES];
  logic [FRAC_W-1:0] frc_q  [SLICES];
  logic [PW-1:0]     acc_q  [SLICES];

  logic signed [INT_W:0] biased;
  logic                  under;
  assign biased = $signed({in_int[INT_W-1], in_int}) + $signed((INT_W + 1)'(BIAS));
  assign under  = biased[INT_W] || (biased == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vld_q[0] <= 1'b0;
    else        vld_q[0] <= in_valid;

  always_ff @(posedge clk) begin
    sgn_q[0]  <= in_sign;
    kind_q[0] <= (in_flags == K_NORM && under) ? K_ZERO : in_flags;
    exp_q[0]  <= biased[INT_W-1:0];
    frc_q[0]  <= in_frac;
    acc_q[0]  <= tab[0][in_frac[FRAC_W-1 -: SLICE_W]];
  end

  for (genvar i = 1; i < SLICES; i++) begin : g_stage
    logic [2*PW-1:0] prod;
    assign prod = acc_q[i-1] * tab[i][frc_q[i-1][FRAC_W-1-i*SLICE_W -: SLICE_W]];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) vld_q[i] <= 1'b0;
      else        vld_q[i] <= vld_q[i-1];

    always_ff @(posedge clk) begin
      sgn_q[i]  <= sgn_q[i-1];
      kind_q[i] <= kind_q[i-1];
      exp_q[i]  <= exp_q[i-1];
      frc_q[i]  <= frc_q[i-1];
      acc_q[i]  <= PW'(prod >> P);
    end
  end

  logic [MAN_W+1:0] rnd;
  logic             carry;
  logic [INT_W-1:0] exp_n;
  assign rnd   = (MAN_W + 2)'(({1'b0, acc_q[LAST]} + (PW + 1)'(1 << (GUARD - 1))) >> GUARD);
  assign carry = rnd[MAN_W+1];
  assign exp_n = exp_q[LAST] + INT_W'(carry);

  assign out_valid = vld_q[LAST];
  assign out_sign  = sgn_q[LAST];

  always_comb begin
    case (kind_q[LAST])
      K_ZERO: begin out_exp = '0;   out_man = '0;      end
      K_INF:  begin out_exp = EMAX; out_man = '0;      end
      K_NORM: begin
        if (exp_n == EMAX) begin out_exp = EMAX;  out_man = '0; end
        else               begin out_exp = exp_n; out_man = rnd[MAN_W-1:0]; end
      end
      default: begin out_exp = EMAX; out_man = NAN_MAN; end
    endcase
  end

  AST_SPECIAL_MAN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_exp == EMAX) |-> (out_man == '0 || out_man == NAN_MAN)); // R2
  AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_exp == '0) |-> (out_man == '0)); // R5
  AST_ACC_NORM: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q[LAST] && kind_q[LAST] == K_NORM) |-> acc_q[LAST][P]); // R6
  AST_UNIT_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q[0] && frc_q[0][FRAC_W-1 -: SLICE_W] == '0) |-> (acc_q[0] == ONE)); // R11
endmodule

// File: tb/tb_lns_to_fp_conv.sv
module tb_lns_to_fp_conv;
  localparam int CLK_PERIOD = 10;
  localparam int NCYC = 19200;
  localparam int NIN  = 16384;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic       rst_n, in_valid, in_sign;
  logic [1:0] in_flags;
  logic [3:0] in_int;
  logic [7:0] in_frac;

  logic       a_valid, a_sign, b_valid, b_sign;
  logic [3:0] a_exp, b_exp;
  logic [7:0] a_man;
  logic [4:0] b_man;

  lns_to_fp_conv dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flags(in_flags),
    .in_sign(in_sign), .in_int(in_int), .in_frac(in_frac),
    .out_valid(a_valid), .out_sign(a_sign), .out_exp(a_exp), .out_man(a_man));

  lns_to_fp_conv #(.INT_W(4), .FRAC_W(8), .MAN_W(5), .SLICES(4), .GUARD(6)) dut_narrow (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flags(in_flags),
    .in_sign(in_sign), .in_int(in_int), .in_frac(in_frac),
    .out_valid(b_valid), .out_sign(b_sign), .out_exp(b_exp), .out_man(b_man));

  int nchk = 0, nfail = 0, ncarry = 0, novf = 0;
  logic        hv   [NCYC];
  logic [13:0] hidx [NCYC];

  task automatic tick(string dn, string req, bit ok, int act, int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", dn, req, act, expv);
    end
  endtask

  task automatic chk(string dn, int M, int L, int c, logic ov, logic os, int oe, int om);
    int e, iv, fr, b, want;
    logic ev, s;
    logic [1:0] fl;
    real m, ulp, hvv;
    e  = c - L;
    ev = (e >= 0) ? hv[e] : 1'b0;
    tick(dn, "R10", ov == ev, int'(ov), int'(ev));
    if (!(ev && ov)) return;
    fl = hidx[e][13:12];
    iv = int'($signed(hidx[e][11:8]));
    fr = int'(hidx[e][7:0]);
    s  = hidx[e][0] ^ hidx[e][5];
    tick(dn, "R9", os == s, int'(os), int'(s));
    ulp = 2.0 ** (-M);
    case (fl)
      2'b00: tick(dn, "R1", oe == 0 && om == 0, oe * 256 + om, 0);
      2'b10: tick(dn, "R2", oe == 15 && om == 0, oe * 256 + om, 15 * 256);
      2'b11: tick(dn, "R3", oe == 15 && om == (1 << (M - 1)), oe * 256 + om, 15 * 256 + (1 << (M - 1)));
      default: begin
        b = iv + 7;
        m = 2.0 ** (real'(fr) / 256.0);
        want = int'(m * (2.0 ** M)) - (1 << M);
        if (b <= 0)
          tick(dn, "R5", oe == 0 && om == 0, oe * 256 + om, 0);
        else if (fr == 0)
          tick(dn, "R11", oe == b && om == 0, oe * 256 + om, b * 256);
        else if (oe == 15) begin
          tick(dn, "R8", b == 14 && om == 0 && (2.0 - m) <= ulp, oe * 256 + om, b * 256 + want);
          novf++;
        end else if (oe == b + 1) begin
          tick(dn, "R7", om == 0 && (2.0 - m) <= ulp, oe * 256 + om, b * 256 + want);
          ncarry++;
        end else begin
          tick(dn, "R4", oe == b, oe, b);
          hvv = 1.0 + real'(om) * ulp;
          tick(dn, "R6", (hvv - m) <= ulp + 1e-12 && (m - hvv) <= ulp + 1e-12, om, want);
        end
      end
    endcase
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int idx;
    idx = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_flags = '0; in_sign = 1'b0; in_int = '0; in_frac = '0;
    repeat (3) @(negedge clk);
    tick("reset", "R10", a_valid == 1'b0, int'(a_valid), 0);
    tick("reset", "R10", b_valid == 1'b0, int'(b_valid), 0);
    rst_n = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      chk("wide", 8, 2, c, a_valid, a_sign, int'(a_exp), int'(a_man));
      chk("narrow", 5, 4, c, b_valid, b_sign, int'(b_exp), int'(b_man));
      if (idx < NIN && (c % 7) != 3) begin
        hv[c]    = 1'b1;
        hidx[c]  = 14'(idx);
        in_valid = 1'b1;
        in_flags = hidx[c][13:12];
        in_int   = hidx[c][11:8];
        in_frac  = hidx[c][7:0];
        in_sign  = hidx[c][0] ^ hidx[c][5];
        idx++;
      end else begin
        hv[c]    = 1'b0;
        hidx[c]  = '0;
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    tick("sweep", "R10", idx == NIN, idx, NIN);
    tick("narrow", "R7", ncarry > 0, ncarry, 1);
    tick("narrow", "R8", novf > 0, novf, 1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule